// File: doc/BRIEF.md
# Bayer Per-Colour Gain Stage

This block sits in a raw-sensor capture path and conditions each Bayer pixel before it is stored. Every incoming pixel is given one of four colour channels. The channel depends on whether the pixel sits on an odd or even line, whether it sits at an odd or even position within that line, and which field is being captured. Each channel has its own black-compensation value and its own gain. The block applies the arithmetic for that channel, adds a shared offset and limits the result to a programmable ceiling.

The stage is fully streaming. It accepts one pixel per clock, with gaps allowed, through a valid qualifier and start-of-line and start-of-frame markers. The same pixel leaves the stage a fixed three cycles later, together with its markers and its colour code. Configuration is written through a simple word-addressed write port. Software should change settings only while no pixels are in flight.

Top module: `bgain_stage`

## Requirements
- R1: After reset the settings are: pattern word 0x4E4E, every gain 256 (unity, 8 fractional bits), every compensation 0, DC level 25, offset 0 and ceiling 4095. While reset is held and directly after it, out_valid is 0.
- R2: Colour codes are 0 = R/Ye, 1 = Gr/Cy, 2 = Gb/G and 3 = B/Mg. When in_fid is 0, the code comes from bits [7:0] of the pattern word. Position index 0..3 (odd line/odd pixel, odd/even, even/odd, even/even) selects bits [2i+1:2i]. The chosen code appears on out_color.
- R3: When in_fid is 1, the code comes from bits [15:8] of the pattern word, using the same position order.
- R4: The pixel that carries in_sof is on an odd line at an odd position. in_sol toggles line parity and restarts pixel parity at odd. Each further valid pixel flips pixel parity. Cycles with in_valid low, including any markers they carry, change neither parity.
- R5: First step: level = pixel − DC level + the signed compensation of the pixel's colour. A negative level becomes 0.
- R6: Second step: the level is multiplied by the gain of the pixel's colour. The product is shifted right by 8 bits, dropping the fraction.
- R7: Third step: the signed offset is added. A negative result gives 0, and a result above the ceiling gives the ceiling.
- R8: Latency is exactly 3 cycles. out_valid, out_sol and out_sof repeat in_valid, in_valid&in_sol and in_valid&in_sof from three cycles earlier.
- R9: Register addresses: 0 is the pattern word. 1..4 are the gains for codes 0..3. 5..8 are the compensations for codes 0..3, each an 8-bit two's-complement value. 9 is the DC level, 10 is the offset (13-bit two's-complement) and 11 is the ceiling. A write to addresses 12..15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sol | input | 1 | First pixel of a line |
| in_sof | input | 1 | First pixel of a frame |
| in_fid | input | 1 | Field identifier |
| in_pix | input | DATA_W | Unsigned raw pixel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register word address |
| wr_data | input | WDATA_W | Register write data |
| out_valid | output | 1 | Output pixel qualifier |
| out_sol | output | 1 | Delayed start-of-line |
| out_sof | output | 1 | Delayed start-of-frame |
| out_pix | output | DATA_W | Processed pixel |
| out_color | output | 2 | Colour code used for the pixel |

## Verification
The bench uses the default widths: 12-bit pixels, 10-bit gains with 8 fractional bits, 8-bit compensation and a 13-bit offset. With a gain ceiling near 4x, a full-scale pixel can overrun a lowered ceiling, while a small pixel combined with negative compensation drops below zero. Both saturation edges are therefore reachable with single pixels. A pattern word that holds four distinct codes per field, different between the two fields, makes every parity and field mistake visible on out_color.

// File: rtl/bgain_pkg.sv
`timescale 1ns/1ps
package bgain_pkg;
  localparam int NCOL  = 4;
  localparam int PAT_W = 2 * NCOL * 2;

  typedef enum logic [1:0] {
    CLR_R_YE  = 2'd0,
    CLR_GR_CY = 2'd1,
    CLR_GB_G  = 2'd2,
    CLR_B_MG  = 2'd3
  } color_e;

  localparam int REG_PATTERN   = 0;
  localparam int REG_GAIN_BASE = 1;
  localparam int REG_COMP_BASE = 5;
  localparam int REG_DC        = 9;
  localparam int REG_OFFSET    = 10;
  localparam int REG_CLIP      = 11;
  localparam int REG_LAST      = 11;

  // per-field codes, listed from the even/even slot down to the odd/odd slot
  localparam logic [7:0] FIELD_RESET = {CLR_GR_CY, CLR_R_YE, CLR_B_MG, CLR_GB_G};
  localparam logic [PAT_W-1:0] PATTERN_RESET = {FIELD_RESET, FIELD_RESET};

  function automatic logic [1:0] pos_index(input logic line_odd, input logic pix_odd);
    return {~line_odd, ~pix_odd};
  endfunction
endpackage

// File: rtl/bgain_regs.sv
`timescale 1ns/1ps
module bgain_regs
  import bgain_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int GAIN_W    = 10,
  parameter int GAIN_FRAC = 8,
  parameter int COMP_W    = 8,
  parameter int OFS_W     = 13,
  parameter int ADDR_W    = 4,
  parameter int WDATA_W   = 16,
  parameter int DC_RESET  = 25
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WDATA_W-1:0]            wr_data,
  output logic [PAT_W-1:0]              pattern,
  output logic [NCOL-1:0][GAIN_W-1:0]   gain_tab,
  output logic [NCOL-1:0][COMP_W-1:0]   comp_tab,
  output logic [DATA_W-1:0]             dc_level,
  output logic [OFS_W-1:0]              offset,
  output logic [DATA_W-1:0]             clip_max
);
  localparam logic [GAIN_W-1:0] GAIN_UNITY = GAIN_W'(1 << GAIN_FRAC);

  logic hit_pat, hit_dc, hit_ofs, hit_clip, ignored_wr;
  assign hit_pat    = wr_en && (wr_addr == ADDR_W'(REG_PATTERN));
  assign hit_dc     = wr_en && (wr_addr == ADDR_W'(REG_DC));
  assign hit_ofs    = wr_en && (wr_addr == ADDR_W'(REG_OFFSET));
  assign hit_clip   = wr_en && (wr_addr == ADDR_W'(REG_CLIP));
  assign ignored_wr = wr_en && (wr_addr > ADDR_W'(REG_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pattern  <= PATTERN_RESET;
      dc_level <= DATA_W'(DC_RESET);
      offset   <= '0;
      clip_max <= '1;
    end else begin
      if (hit_pat)  pattern  <= wr_data[PAT_W-1:0];
      if (hit_dc)   dc_level <= wr_data[DATA_W-1:0];
      if (hit_ofs)  offset   <= wr_data[OFS_W-1:0];
      if (hit_clip) clip_max <= wr_data[DATA_W-1:0];
    end
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_chan
    logic hit_gain, hit_comp;
    assign hit_gain = wr_en && (wr_addr == ADDR_W'(REG_GAIN_BASE + c));
    assign hit_comp = wr_en && (wr_addr == ADDR_W'(REG_COMP_BASE + c));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        gain_tab[c] <= GAIN_UNITY;
        comp_tab[c] <= '0;
      end else begin
        if (hit_gain) gain_tab[c] <= wr_data[GAIN_W-1:0];
        if (hit_comp) comp_tab[c] <= wr_data[COMP_W-1:0];
      end
    end
  end

  // R9
  unused_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignored_wr |=> $stable({pattern, gain_tab, comp_tab, dc_level, offset, clip_max}))
    else $error("write to unused address changed a setting");
endmodule

// File: rtl/bgain_phase.sv
`timescale 1ns/1ps
module bgain_phase
  import bgain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sol,
  input  logic             in_sof,
  input  logic             in_fid,
  input  logic [PAT_W-1:0] pattern,
  output logic [1:0]       code
);
  logic line_odd_q, pix_odd_q;
  logic cur_line_odd, cur_pix_odd;
  logic [1:0] slot;

  assign cur_line_odd = in_sof ? 1'b1 : (in_sol ? ~line_odd_q : line_odd_q);
  assign cur_pix_odd  = (in_sof || in_sol) ? 1'b1 : pix_odd_q;
  assign slot         = pos_index(cur_line_odd, cur_pix_odd);
  assign code         = pattern[{in_fid, slot, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_odd_q <= 1'b0;
      pix_odd_q  <= 1'b1;
    end else if (in_valid) begin
      line_odd_q <= cur_line_odd;
      pix_odd_q  <= ~cur_pix_odd;
    end
  end

  // R4
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (line_odd_q && !pix_odd_q))
    else $error("frame start did not restart parity");

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(line_odd_q) && $stable(pix_odd_q)))
    else $error("parity moved on an idle cycle");
endmodule

// File: rtl/bgain_arith.sv
`timescale 1ns/1ps
module bgain_arith
  import bgain_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int GAIN_W    = 10,
  parameter int GAIN_FRAC = 8,
  parameter int COMP_W    = 8,
  parameter int OFS_W     = 13
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic                        in_sol,
  input  logic                        in_sof,
  input  logic [DATA_W-1:0]           in_pix,
  input  logic [1:0]                  in_code,
  input  logic [NCOL-1:0][GAIN_W-1:0] gain_tab,
  input  logic [NCOL-1:0][COMP_W-1:0] comp_tab,
  input  logic [DATA_W-1:0]           dc_level,
  input  logic [OFS_W-1:0]            offset,
  input  logic [DATA_W-1:0]           clip_max,
  output logic                        out_valid,
  output logic                        out_sol,
  output logic                        out_sof,
  output logic [DATA_W-1:0]           out_pix,
  output logic [1:0]                  out_color
);
  localparam int LVL_W  = DATA_W + 1;
  localparam int S1_W   = DATA_W + 2;
  localparam int MUL_W  = LVL_W + GAIN_W;
  localparam int PROD_W = MUL_W - GAIN_FRAC;
  localparam int SUM_W  = (((PROD_W + 1) > OFS_W) ? (PROD_W + 1) : OFS_W) + 1;

  function automatic logic [LVL_W-1:0] f_level(input logic [DATA_W-1:0] pix,
                                               input logic [DATA_W-1:0] dc,
                                               input logic [COMP_W-1:0] comp);
    logic signed [S1_W-1:0] t;
    t = $signed({2'b00, pix}) - $signed({2'b00, dc})
      + $signed({{(S1_W-COMP_W){comp[COMP_W-1]}}, comp});
    return t[S1_W-1] ? '0 : t[LVL_W-1:0];
  endfunction

  function automatic logic [PROD_W-1:0] f_gain(input logic [LVL_W-1:0] lvl,
                                               input logic [GAIN_W-1:0] gain);
    logic [MUL_W-1:0] p;
    p = MUL_W'(lvl) * MUL_W'(gain);
    return p[MUL_W-1:GAIN_FRAC];
  endfunction

  function automatic logic [DATA_W-1:0] f_clip(input logic [PROD_W-1:0] prod,
                                               input logic [OFS_W-1:0]  ofs,
                                               input logic [DATA_W-1:0] ceil);
    logic signed [SUM_W-1:0] s;
    s = $signed({{(SUM_W-PROD_W){1'b0}}, prod})
      + $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    if (s[SUM_W-1]) return '0;
    if (s > $signed({{(SUM_W-DATA_W){1'b0}}, ceil})) return ceil;
    return s[DATA_W-1:0];
  endfunction

  logic              a_vld, a_sol, a_sof, b_vld, b_sol, b_sof;
  logic [1:0]        a_code, b_code;
  logic [LVL_W-1:0]  a_lvl;
  logic [PROD_W-1:0] b_prod;
  logic [1:0]        warm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_vld <= 1'b0; a_sol <= 1'b0; a_sof <= 1'b0; a_code <= '0; a_lvl <= '0;
      b_vld <= 1'b0; b_sol <= 1'b0; b_sof <= 1'b0; b_code <= '0; b_prod <= '0;
      out_valid <= 1'b0; out_sol <= 1'b0; out_sof <= 1'b0;
      out_color <= '0; out_pix <= '0;
      warm <= '0;
    end else begin
      a_vld  <= in_valid;
      a_sol  <= in_valid & in_sol;
      a_sof  <= in_valid & in_sof;
      a_code <= in_code;
      a_lvl  <= f_level(in_pix, dc_level, comp_tab[in_code]);
      b_vld  <= a_vld;
      b_sol  <= a_sol;
      b_sof  <= a_sof;
      b_code <= a_code;
      b_prod <= f_gain(a_lvl, gain_tab[a_code]);
      out_valid <= b_vld;
      out_sol   <= b_sol;
      out_sof   <= b_sof;
      out_color <= b_code;
      out_pix   <= f_clip(b_prod, offset, clip_max);
      if (warm != 2'd3) warm <= warm + 2'd1;
    end
  end

  // R8
  latency_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)))
    else $error("valid not delayed by three cycles");

  // R8
  latency_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_sof == $past(in_valid && in_sof, 3)
                        && out_sol == $past(in_valid && in_sol, 3)))
    else $error("markers not delayed by three cycles");

  // R7
  ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && out_valid) |-> (out_pix <= $past(clip_max)))
    else $error("output above ceiling");
endmodule

// File: rtl/bgain_stage.sv
`timescale 1ns/1ps
module bgain_stage
  import bgain_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int GAIN_W    = 10,
  parameter int GAIN_FRAC = 8,
  parameter int COMP_W    = 8,
  parameter int OFS_W     = 13,
  parameter int ADDR_W    = 4,
  parameter int WDATA_W   = 16,
  parameter int DC_RESET  = 25
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_sol,
  input  logic               in_sof,
  input  logic               in_fid,
  input  logic [DATA_W-1:0]  in_pix,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [WDATA_W-1:0] wr_data,
  output logic               out_valid,
  output logic               out_sol,
  output logic               out_sof,
  output logic [DATA_W-1:0]  out_pix,
  output logic [1:0]         out_color
);
  logic [PAT_W-1:0]            pattern;
  logic [NCOL-1:0][GAIN_W-1:0] gain_tab;
  logic [NCOL-1:0][COMP_W-1:0] comp_tab;
  logic [DATA_W-1:0]           dc_level, clip_max;
  logic [OFS_W-1:0]            offset;
  logic [1:0]                  code;

  bgain_regs #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .COMP_W(COMP_W),
    .OFS_W(OFS_W), .ADDR_W(ADDR_W), .WDATA_W(WDATA_W), .DC_RESET(DC_RESET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pattern(pattern), .gain_tab(gain_tab), .comp_tab(comp_tab),
    .dc_level(dc_level), .offset(offset), .clip_max(clip_max)
  );

  bgain_phase u_phase (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_fid(in_fid), .pattern(pattern), .code(code)
  );

  bgain_arith #(
    .DATA_W(DATA_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
    .COMP_W(COMP_W), .OFS_W(OFS_W)
  ) u_arith (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_pix(in_pix), .in_code(code),
    .gain_tab(gain_tab), .comp_tab(comp_tab), .dc_level(dc_level),
    .offset(offset), .clip_max(clip_max),
    .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof),
    .out_pix(out_pix), .out_color(out_color)
  );
endmodule

// File: tb/tb_bgain_stage.sv
`timescale 1ns/1ps
module tb_bgain_stage;
  localparam int DATA_W = 12, ADDR_W = 4, WDATA_W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0, in_fid = 1'b0;
  logic [DATA_W-1:0] in_pix = '0;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [WDATA_W-1:0] wr_data = '0;
  logic out_valid, out_sol, out_sof;
  logic [DATA_W-1:0] out_pix;
  logic [1:0] out_color;

  bgain_stage dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
    .in_sof(in_sof), .in_fid(in_fid), .in_pix(in_pix), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .out_valid(out_valid),
    .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix), .out_color(out_color)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int e_pix[256], e_col[256], e_sol[256], e_sof[256], e_cyc[256];
  string e_tag[256];
  int wr_i = 0, rd_i = 0;

  // independent model of the settings (R1 reset values)
  int m_pat = 16'h4E4E;
  int m_gain[4] = '{256, 256, 256, 256};
  int m_comp[4] = '{0, 0, 0, 0};
  int m_dc = 25, m_ofs = 0, m_clip = 4095;
  int lv[8];

  function automatic int ref_pix(int p, int c);
    int t;
    t = p - m_dc + m_comp[c];
    if (t < 0) t = 0;
    t = (t * m_gain[c]) / 256;
    t = t + m_ofs;
    if (t < 0) t = 0;
    if (t > m_clip) t = m_clip;
    return t;
  endfunction

  function automatic int ref_col(int fid, int ln, int px);
    int idx;
    idx = (ln % 2) * 2 + (px % 2);
    return (m_pat >> (fid * 8 + idx * 2)) & 3;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (rd_i >= wr_i) chk(1'b0, "R8", "unexpected out_valid", 1, 0);
      else begin
        int k;
        k = rd_i % 256;
        chk(int'(out_pix) == e_pix[k], e_tag[k], "pixel", int'(out_pix), e_pix[k]);
        chk(int'(out_color) == e_col[k], e_tag[k], "colour", int'(out_color), e_col[k]);
        chk(int'(out_sol) == e_sol[k], "R8", "sol", int'(out_sol), e_sol[k]);
        chk(int'(out_sof) == e_sof[k], "R8", "sof", int'(out_sof), e_sof[k]);
        chk(cyc == e_cyc[k] + 3, "R8", "latency", cyc - e_cyc[k], 3);
        rd_i++;
      end
    end
  end

  task automatic set_model(int a, int d);
    if (a == 0) m_pat = d & 16'hFFFF;
    else if (a >= 1 && a <= 4) m_gain[a-1] = d & 1023;
    else if (a >= 5 && a <= 8) m_comp[a-5] = ((d & 255) >= 128) ? (d & 255) - 256 : (d & 255);
    else if (a == 9) m_dc = d & 4095;
    else if (a == 10) m_ofs = ((d & 8191) >= 4096) ? (d & 8191) - 8192 : (d & 8191);
    else if (a == 11) m_clip = d & 4095;
  endtask

  task automatic wreg(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = WDATA_W'(d);
    @(negedge clk);
    wr_en = 1'b0;
    set_model(a, d);
  endtask

  task automatic push(int v, int sol, int sof, int fid, int ln, int px, string tag);
    int k;
    int c;
    @(negedge clk);
    in_valid = 1'b1; in_sol = sol[0]; in_sof = sof[0]; in_fid = fid[0];
    in_pix = DATA_W'(v);
    k = wr_i % 256;
    c = ref_col(fid, ln, px);
    e_col[k] = c; e_pix[k] = ref_pix(v, c); e_sol[k] = sol; e_sof[k] = sof;
    e_cyc[k] = cyc; e_tag[k] = tag;
    wr_i++;
  endtask

  task automatic idle(int n, bit junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; in_sol = junk; in_sof = junk;
      in_pix = junk ? '1 : '0;
    end
  endtask

  task automatic send_frame(int lines, int pxs, int fid, int gap, int seed, string tag);
    for (int ln = 0; ln < lines; ln++)
      for (int px = 0; px < pxs; px++) begin
        push((seed + ln * 37 + px * 101) % 4096, int'(px == 0),
             int'(ln == 0 && px == 0), fid, ln, px, tag);
        if (gap > 0) idle(gap, 1'b1);
      end
    idle(1, 1'b0);
  endtask

  task automatic send_list(int fid, string tag);
    for (int ln = 0; ln < 2; ln++)
      for (int px = 0; px < 4; px++)
        push(lv[ln*4+px], int'(px == 0), int'(ln == 0 && px == 0), fid, ln, px, tag);
    idle(1, 1'b0);
  endtask

  task automatic drain(string tag);
    idle(6, 1'b0);
    chk(rd_i == wr_i, tag, "outputs drained", rd_i, wr_i);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_defaults;
    send_frame(2, 4, 0, 0, 100, "R1");
    send_frame(2, 4, 1, 0, 700, "R1");
    drain("R1");
  endtask

  task automatic t_pattern;
    wreg(0, 16'h1BE4);
    send_frame(2, 4, 0, 0, 55, "R2");
    send_frame(2, 4, 1, 0, 900, "R3");
    drain("R2");
  endtask

  task automatic t_parity;
    send_frame(3, 5, 0, 1, 7, "R4");
    send_frame(3, 5, 1, 2, 9, "R4");
    send_frame(3, 3, 0, 0, 11, "R4");
    drain("R4");
  endtask

  task automatic t_arith;
    wreg(9, 20);
    wreg(5, 16'h00CE);
    wreg(6, 100);
    wreg(7, 0);
    wreg(8, 16'h00FB);
    wreg(1, 1023);
    wreg(2, 128);
    wreg(3, 300);
    wreg(4, 256);
    wreg(10, 16'h1FD8);
    wreg(11, 3000);
    lv = '{0, 4095, 30, 4095, 4095, 10, 1000, 4095};
    send_list(0, "R5 R6 R7");
    lv = '{2000, 50, 75, 3333, 1, 400, 3999, 64};
    send_list(1, "R5 R6 R7");
    wreg(10, 500);
    wreg(11, 4095);
    lv = '{100, 200, 300, 400, 500, 600, 700, 4095};
    send_list(0, "R6 R7");
    drain("R7");
  endtask

  task automatic t_regmap;
    for (int a = 12; a < 16; a++) wreg(a, 16'hFFFF);
    send_frame(2, 4, 0, 0, 300, "R9");
    send_frame(2, 4, 1, 0, 1300, "R9");
    drain("R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_defaults();
    t_pattern();
    t_parity();
    t_arith();
    t_regmap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule